// File: doc/BRIEF.md
# Buffered PWM Pulse Generator Channel

This block is a single channel of a pulse-width generator. A 16-bit down counter steps once per prescaled count tick and runs from a loaded cycle value down to zero. The output pin goes high when the count equals the active duty value and goes low when the counter underflows past zero (a borrow). Software writes new cycle and duty values into holding buffers at any time. The active copies take those values only at a borrow or at a start, so the period in progress is never disturbed.

A trigger input starts the channel. A further trigger while it runs restarts the count, but only when restart is allowed. A stop command freezes the counter. A fixed-level mode drives the pin to a chosen constant, and a polarity bit inverts the waveform. One of four timer events sets a sticky interrupt flag, which software clears. The same event sends a one-cycle DMA request strobe.

Top module: `pwm_chan`

## Requirements
- R1: After synchronous reset the count reads 0xFFFF, and `pwm_o`, `irq_o` and `dma_o` are low. The control register resets to all zeros.
- R2: Writes go to the register selected by `wr_addr`: 0 is the cycle buffer, 1 is the duty buffer and 2 is control. A trigger on a stopped channel loads the counter with the cycle buffer. The counter then falls by one per tick and reloads after reaching zero, so one period lasts cycle+1 ticks.
- R3: Control bits [1:0] select the tick rate as the clock divided by 1, 4, 16 or 64 (codes 0 to 3). The prescaler is cleared at start, so with divisor P the first tick falls P clocks after the start edge.
- R4: On a tick where the count equals the active duty value, the output level is set to 1. On a borrow tick it is cleared to 0. When both happen on one tick the set wins, so duty 0 holds the output high after the first borrow. Duty above cycle keeps the output low.
- R5: Buffer writes do not change the period in progress. At a borrow the counter reloads from the cycle buffer, and the active duty takes the duty buffer at that same edge.
- R6: Control bit 7 inverts the output. Control bit 5 selects fixed mode, in which `pwm_o` equals control bit 6 while counting goes on.
- R7: Control bits [3:2] choose the interrupt event: 0 is start, 1 is borrow, 2 is duty match and 3 is borrow or match. The event sets a flag that stays set.
- R8: Writing control with bit 9 set clears the flag. `irq_o` is the flag gated by control bit 4. `dma_o` is a one-cycle pulse after each selected event while bit 4 is set.
- R9: A trigger while running restarts the count from the cycle buffer only if control bit 8 is set. Otherwise it is ignored.
- R10: Writing control with bit 10 set stops the channel. The count then holds, the output rests at the level of bit 7, and the stop wins over a trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| trig | input | 1 | Start / restart trigger |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request level |
| dma_o | output | 1 | DMA request strobe |

## Verification
A duty match and a borrow can land on the same count tick. With a duty value of zero the final step of every period both matches and borrows. The bench sweeps duty from 0 through cycle+1 over small cycle values and expects the output to latch high and stay high after the first borrow, because the set rule wins. A restart trigger and a stop command can also fall in the same cycle. That case is driven directly, and the frozen count shows that the stop won.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int CNT_W    = 16;
    localparam int PSC_W    = 6;
    localparam int CLR_BIT  = 9;
    localparam int STOP_BIT = 10;

    typedef enum logic [1:0] {
        DIV1  = 2'd0,
        DIV4  = 2'd1,
        DIV16 = 2'd2,
        DIV64 = 2'd3
    } clk_div_e;

    typedef enum logic [1:0] {
        SRC_START  = 2'd0,
        SRC_BORROW = 2'd1,
        SRC_MATCH  = 2'd2,
        SRC_EITHER = 2'd3
    } irq_src_e;

    typedef enum logic [1:0] {
        ADDR_CYCLE = 2'd0,
        ADDR_DUTY  = 2'd1,
        ADDR_CTRL  = 2'd2
    } reg_addr_e;

    // stored control fields, bit 0 at the bottom
    typedef struct packed {
        logic     restart_en;  // 8
        logic     invert;      // 7
        logic     fix_lvl;     // 6
        logic     fix_en;      // 5
        logic     irq_en;      // 4
        irq_src_e src;         // 3:2
        clk_div_e div;         // 1:0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic start;
        logic stop;
        logic match;
        logic borrow;
    } evt_t;

    function automatic logic [PSC_W-1:0] div_limit(clk_div_e d);
        case (d)
            DIV1:    return PSC_W'(0);
            DIV4:    return PSC_W'(3);
            DIV16:   return PSC_W'(15);
            default: return PSC_W'(63);
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     clr,
    input  clk_div_e div,
    output logic     tick
);

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] lim;

    assign lim  = div_limit(div);
    assign tick = run && !clr && (psc_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            psc_q <= '0;
        end else if (tick) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         stop,
    input  logic         tick,
    input  logic [W-1:0] cyc_buf,
    input  logic [W-1:0] duty_buf,
    output logic [W-1:0] count,
    output logic         running,
    output logic         match,
    output logic         borrow
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] duty_act_q;
    logic         run_q;
    logic         step;

    assign step    = tick && !start && !stop;
    assign borrow  = step && (cnt_q == '0);
    assign match   = step && (cnt_q == duty_act_q);
    assign count   = cnt_q;
    assign running = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '1;
            duty_act_q <= '1;
            run_q      <= 1'b0;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (start) begin
            run_q      <= 1'b1;
            cnt_q      <= cyc_buf;
            duty_act_q <= duty_buf;
        end else if (borrow) begin
            cnt_q      <= cyc_buf;
            duty_act_q <= duty_buf;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_pinctl.sv
module pwm_pinctl
    import pwm_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  evt,
    input  logic  clr_flag,
    input  ctrl_t ctrl,
    output logic  raw,
    output logic  pwm_o,
    output logic  irq_o,
    output logic  dma_o
);

    logic raw_q;
    logic flag_q;
    logic dma_q;
    logic sel_evt;

    always_comb begin
        case (ctrl.src)
            SRC_START:  sel_evt = evt.start;
            SRC_BORROW: sel_evt = evt.borrow;
            SRC_MATCH:  sel_evt = evt.match;
            default:    sel_evt = evt.borrow || evt.match;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            flag_q <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (evt.stop || evt.start) begin
                raw_q <= 1'b0;
            end else if (evt.match) begin
                raw_q <= 1'b1;
            end else if (evt.borrow) begin
                raw_q <= 1'b0;
            end

            if (sel_evt) begin
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end

            dma_q <= sel_evt && ctrl.irq_en;
        end
    end

    assign raw   = raw_q;
    assign pwm_o = ctrl.fix_en ? ctrl.fix_lvl : (raw_q ^ ctrl.invert);
    assign irq_o = flag_q && ctrl.irq_en;
    assign dma_o = dma_q;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         trig,
    output logic [W-1:0] count_o,
    output logic         pwm_o,
    output logic         irq_o,
    output logic         dma_o
);

    logic [W-1:0] cyc_buf;
    logic [W-1:0] duty_buf;
    ctrl_t        ctrl_q;
    logic         ctrl_wr;
    logic         stop;
    logic         clr_flag;
    logic         start;
    logic         running;
    logic         tick;
    logic         match;
    logic         borrow;
    logic         raw;
    evt_t         evt;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign stop     = ctrl_wr && wr_data[STOP_BIT];
    assign clr_flag = ctrl_wr && wr_data[CLR_BIT];
    assign start    = trig && !stop && (!running || ctrl_q.restart_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_buf  <= '1;
            duty_buf <= '1;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CYCLE: cyc_buf  <= wr_data;
                ADDR_DUTY:  duty_buf <= wr_data;
                ADDR_CTRL:  ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:    ;
            endcase
        end
    end

    pwm_prescale psc_i (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .clr  (start),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    pwm_count #(.W(W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .tick     (tick),
        .cyc_buf  (cyc_buf),
        .duty_buf (duty_buf),
        .count    (count_o),
        .running  (running),
        .match    (match),
        .borrow   (borrow)
    );

    assign evt = '{start: start, stop: stop, match: match, borrow: borrow};

    pwm_pinctl pin_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_flag (clr_flag),
        .ctrl     (ctrl_q),
        .raw      (raw),
        .pwm_o    (pwm_o),
        .irq_o    (irq_o),
        .dma_o    (dma_o)
    );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [W-1:0] count_o,
    input logic [W-1:0] cyc_buf,
    input logic         tick,
    input logic         running,
    input logic         start,
    input logic         stop,
    input logic         match,
    input logic         borrow,
    input logic         raw,
    input logic [1:0]   div
);

    assert_reset_val_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_o == '1 && !raw));

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !start && !stop && count_o != '0) |=> ((count_o + 1'b1) == $past(count_o)));

    assert_tick_space_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && div != 2'd0 && !wr_en) |=> !tick);

    assert_match_sets_R4: assert property (@(posedge clk) disable iff (rst)
        match |=> raw);

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        borrow |=> (count_o == $past(cyc_buf)));

    assert_stop_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(count_o));

endmodule

bind pwm_chan pwm_chan_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .count_o (count_o),
    .cyc_buf (cyc_buf),
    .tick    (tick),
    .running (running),
    .start   (start),
    .stop    (stop),
    .match   (match),
    .borrow  (borrow),
    .raw     (raw),
    .div     (ctrl_q.div)
);

// File: tb/pwm_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        trig = 1'b0;
    logic [15:0] count_o;
    logic        pwm_o;
    logic        irq_o;
    logic        dma_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_chan dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .trig    (trig),
        .count_o (count_o),
        .pwm_o   (pwm_o),
        .irq_o   (irq_o),
        .dma_o   (dma_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] cw(int dv, int src, bit en, bit fix, bit lvl,
                                       bit inv, bit rsen, bit clr, bit stp);
        logic [15:0] w;
        w = 16'd0;
        w[1:0] = dv[1:0];
        w[3:2] = src[1:0];
        w[4] = en;
        w[5] = fix;
        w[6] = lvl;
        w[7] = inv;
        w[8] = rsen;
        w[9] = clr;
        w[10] = stp;
        return w;
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        wr_en = 1'b1;
        wr_addr = a[1:0];
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic go();
        trig = 1'b1;
        step();
        trig = 1'b0;
    endtask

    task automatic setup(input logic [15:0] ctl, input int c, input int d);
        wr(2, ctl | 16'h0400);
        wr(0, c[15:0]);
        wr(1, d[15:0]);
    endtask

    function automatic int exp_cnt(int c, int n);
        return c - (n % (c + 1));
    endfunction

    function automatic int exp_raw(int c, int d, int n);
        int v;
        if (n == 0) return 0;
        if (d == 0) return (n >= c + 1) ? 1 : 0;
        if (d > c) return 0;
        v = c - ((n - 1) % (c + 1));
        return (v >= 1 && v <= d) ? 1 : 0;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 count", count_o, 16'hFFFF);
        chk("R1 pwm", pwm_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 dma", dma_o, 0);

        // R2 R3 R4 R6 sweep over cycle, duty, divider, polarity
        for (int dv = 0; dv < 2; dv++) begin
            for (int c = 0; c <= 5; c++) begin
                for (int d = 0; d <= c + 1; d++) begin
                    int p;
                    bit inv;
                    p = (dv == 0) ? 1 : 4;
                    inv = ((c + d) % 2) == 1;
                    setup(cw(dv, 0, 0, 0, 0, inv, 0, 0, 0), c, d);
                    go();
                    for (int t = 0; t <= 3 * p * (c + 1) + 2; t++) begin
                        chk("R2 R3 count", count_o, exp_cnt(c, t / p));
                        chk("R4 R6 pwm", pwm_o, exp_raw(c, d, t / p) ^ int'(inv));
                        step();
                    end
                end
            end
        end

        // R3 large dividers
        for (int dv = 2; dv < 4; dv++) begin
            int p;
            p = (dv == 2) ? 16 : 64;
            setup(cw(dv, 0, 0, 0, 0, 0, 0, 0, 0), 2, 1);
            go();
            for (int t = 0; t <= 3 * p * 3; t++) begin
                chk("R3 count", count_o, exp_cnt(2, t / p));
                chk("R3 pwm", pwm_o, exp_raw(2, 1, t / p));
                step();
            end
        end

        // R5 mid-period buffer writes
        setup(cw(0, 0, 0, 0, 0, 0, 0, 0, 0), 3, 1);
        go();
        chk("R5 count t0", count_o, 3);
        step();
        chk("R5 count t1", count_o, 2);
        wr(0, 16'd5);
        chk("R5 count t2", count_o, 1);
        wr(1, 16'd5);
        chk("R5 count t3", count_o, 0);
        chk("R5 pwm t3", pwm_o, 1);
        step();
        chk("R5 reload t4", count_o, 5);
        chk("R5 pwm t4", pwm_o, 0);
        step();
        chk("R5 count t5", count_o, 4);
        chk("R5 new duty t5", pwm_o, 1);

        // R7 R8 interrupt sources, C=3 D=2
        for (int src = 0; src < 4; src++) begin
            setup(cw(0, src, 1, 0, 0, 0, 0, 1, 0), 3, 2);
            go();
            for (int t = 0; t <= 9; t++) begin
                int e;
                int f;
                case (src)
                    0: begin e = (t == 0); f = 1; end
                    1: begin e = (t == 4 || t == 8); f = (t >= 4); end
                    2: begin e = (t == 2 || t == 6); f = (t >= 2); end
                    default: begin e = (t == 2 || t == 4 || t == 6 || t == 8); f = (t >= 2); end
                endcase
                chk("R7 irq", irq_o, f);
                chk("R8 dma", dma_o, e);
                step();
            end
        end
        // R8 clear
        wr(2, cw(0, 3, 1, 0, 0, 0, 0, 1, 1));
        chk("R8 clear", irq_o, 0);
        // R8 enable gating
        setup(cw(0, 0, 0, 0, 0, 0, 0, 1, 0), 3, 2);
        go();
        chk("R8 masked irq", irq_o, 0);
        chk("R8 masked dma", dma_o, 0);
        wr(2, cw(0, 0, 1, 0, 0, 0, 0, 0, 0));
        chk("R8 unmasked irq", irq_o, 1);
        chk("R8 no dma", dma_o, 0);

        // R6 fixed mode
        for (int lvl = 0; lvl < 2; lvl++) begin
            setup(cw(0, 0, 0, 1, lvl[0], 0, 0, 0, 0), 2, 1);
            go();
            for (int t = 0; t <= 8; t++) begin
                chk("R6 fixed pwm", pwm_o, lvl);
                chk("R6 fixed count", count_o, exp_cnt(2, t));
                step();
            end
        end

        // R9 restart enabled / disabled
        for (int en = 0; en < 2; en++) begin
            setup(cw(0, 0, 0, 0, 0, 0, en[0], 0, 0), 5, 3);
            go();
            step();
            step();
            chk("R9 before trig", count_o, 3);
            go();
            chk("R9 after trig", count_o, en ? 5 : 2);
        end

        // R10 stop holds count, output inactive
        setup(cw(0, 0, 0, 0, 0, 1, 1, 0, 0), 5, 3);
        go();
        step();
        step();
        step();
        chk("R10 running pwm", pwm_o, 0);
        wr(2, cw(0, 0, 0, 0, 0, 1, 1, 0, 1));
        chk("R10 held count", count_o, 2);
        chk("R10 inactive pwm", pwm_o, 1);
        repeat (3) step();
        chk("R10 still held", count_o, 2);
        trig = 1'b1;
        wr(2, cw(0, 0, 0, 0, 0, 1, 1, 0, 1));
        trig = 1'b0;
        chk("R10 stop beats trig", count_o, 2);
        step();
        chk("R10 stop beats trig later", count_o, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule